// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregation Controller

This block gathers interrupt events from several framer channels and folds them into one interrupt request line. Each channel owns a set of 16-bit sticky status words, and each word has its own 16-bit mask. A status word with any set bit that its mask leaves open raises one bit of an interrupt vector. A per-word vector mask and a per-channel enable gate that bit. Any vector bit that remains pulls the active-low, open-drain request line low. The line is modelled here as a drive-low enable.

Software uses a single-cycle register port. Reading a status word returns its contents and empties it. Software also programs the masks and a per-channel control word, which holds an interrupt enable, a live bit and a self-clearing channel reset. A global initialisation pin (`init_n`) holds every status word empty and keeps the line released. The masks are not touched while it is low.

Top module: `irq_aggregator`

## Requirements
- R1: An event pulse on `ev_pulse` bit (c*N_REG+r)*16+b sets bit b of status word r of channel c on the next clock edge. The bit stays set until that word is read, whatever the masks hold.
- R2: A read strobe loads `rd_data` at the next clock edge. For a status word, the loaded value is the content before the clear. The word is empty after that edge, except for bits whose event pulse arrived in the same cycle as the read; those bits stay set.
- R3: Vector bit c*N_REG+r is 1 exactly when three conditions all hold: status word r of channel c has a set bit whose mask bit is 0 (a mask bit of 1 blocks that bit), vector-mask bit r of the channel is 0, and the channel's enable bit is 1.
- R4: `irq_drive_low` is 1 whenever any vector bit is 1 and `init_n` is high. It stays 1 until every contributing status word has been read empty.
- R5: A status word whose vector-mask bit is 1 still latches and clears on read, but it cannot raise its vector bit.
- R6: While a channel's enable bit (control bit 0) is 0, its status words keep latching and clearing on read, but all its vector bits are 0.
- R7: While a channel's live bit (control bit 1) is 0, all its status words are held at zero and ignore events.
- R8: While `init_n` is low, every status word in every channel is held at zero and ignores events, and `irq_drive_low` is 0. Mask and vector-mask contents are kept.
- R9: Reset (`rst_n` low) sets every mask and vector mask to 0, every control word to 0, `rd_data` to 0 and all status to 0. Writing 1 to control bit 2 of one channel does the same for that channel only. Bit 2 reads back as 0.
- R10: The address is {channel, select}. Select values 0..N_REG-1 are the status words; these are read-only, and writes to them are ignored. Select values N_REG..2*N_REG-1 are the masks. Select 2*N_REG is the vector mask, with bit r for word r. Select 2*N_REG+1 is the control word. Unused bits read as 0, and reads of anything other than a status word clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Global initialisation hold, active low |
| ev_pulse | input | N_CH*N_REG*16 | Single-cycle event pulses, one per status bit |
| addr | input | CH_W+SEL_W | {channel, select} register address |
| rd_stb | input | 1 | Read strobe, one cycle |
| wr_stb | input | 1 | Write strobe, one cycle |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq_vector | output | N_CH*N_REG | Gated per-word interrupt vector |
| irq_drive_low | output | 1 | 1 when the request line must be pulled low |

## Verification
The hardest case is an event that lands on a status word in the same cycle as the read that clears it. The old contents must come out on `rd_data` and the new bit must survive. The bench drives the read strobe and the event pulse at the same falling edge, then reads the word a second time to recover the survivor. The other hard case is the request line staying asserted while some words are emptied and others are still pending. The bench queues events on two words and reads them one at a time, checking the line after each read.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int DATA_W = 16;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_LIVE_BIT = 1;
  localparam int CTRL_RST_BIT  = 2;

  // a status word is pending when any latched bit is not blocked by its mask
  function automatic logic word_pending(input logic [DATA_W-1:0] stat,
                                        input logic [DATA_W-1:0] mask);
    return |(stat & ~mask);
  endfunction

  // next value of a sticky status word
  function automatic logic [DATA_W-1:0] sticky_next(input logic [DATA_W-1:0] stat,
                                                    input logic [DATA_W-1:0] ev,
                                                    input logic              clr,
                                                    input logic              hold);
    logic [DATA_W-1:0] kept;
    kept = clr ? '0 : stat;
    return hold ? '0 : (kept | ev);
  endfunction
endpackage

// File: rtl/irqa_status_cell.sv
module irqa_status_cell
  import irqa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              ch_rst,
  input  logic              rd_clr,
  input  logic [DATA_W-1:0] ev,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              pending
);
  logic stat_hold;
  assign stat_hold = hold || ch_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= sticky_next(stat_q, ev, rd_clr, stat_hold);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (ch_rst) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= wr_data;
    end
  end

  assign pending = word_pending(stat_q, mask_q);

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_hold && !rd_clr) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R1
  AST_CLR_LEAVES_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !stat_hold) |=> (stat_q == $past(ev))); // R2
  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (stat_q == '0)); // R7
endmodule

// File: rtl/irqa_channel.sv
module irqa_channel
  import irqa_pkg::*;
#(
  parameter int N_REG = 4,
  parameter int SEL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_n,
  input  logic [N_REG*DATA_W-1:0] ev,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    rd_stb,
  input  logic                    wr_stb,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DATA_W-1:0]       rd_word,
  output logic [N_REG-1:0]        vec
);
  localparam int SEL_VMASK = 2 * N_REG;
  localparam int SEL_CTRL  = 2 * N_REG + 1;

  logic              irq_en_q;
  logic              live_q;
  logic [N_REG-1:0]  vmask_q;
  logic              wr_ctrl;
  logic              wr_vmask;
  logic              ch_rst;
  logic              hold;
  logic [N_REG-1:0]  pend;
  logic [DATA_W-1:0] stat_w [N_REG];
  logic [DATA_W-1:0] mask_w [N_REG];

  assign wr_ctrl  = wr_stb && (sel == SEL_W'(SEL_CTRL));
  assign wr_vmask = wr_stb && (sel == SEL_W'(SEL_VMASK));
  assign ch_rst   = wr_ctrl && wr_data[CTRL_RST_BIT];
  assign hold     = !init_n || !live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      live_q   <= 1'b0;
      vmask_q  <= '0;
    end else if (ch_rst) begin
      irq_en_q <= 1'b0;
      live_q   <= 1'b0;
      vmask_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        irq_en_q <= wr_data[CTRL_EN_BIT];
        live_q   <= wr_data[CTRL_LIVE_BIT];
      end
      if (wr_vmask) begin
        vmask_q <= wr_data[N_REG-1:0];
      end
    end
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_word
    logic rd_clr;
    logic wr_mask;
    assign rd_clr  = rd_stb && (sel == SEL_W'(r));
    assign wr_mask = wr_stb && (sel == SEL_W'(N_REG + r));

    irqa_status_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .ch_rst  (ch_rst),
      .rd_clr  (rd_clr),
      .ev      (ev[r*DATA_W +: DATA_W]),
      .wr_mask (wr_mask),
      .wr_data (wr_data),
      .stat_q  (stat_w[r]),
      .mask_q  (mask_w[r]),
      .pending (pend[r])
    );

    assign vec[r] = irq_en_q && !vmask_q[r] && pend[r];
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (sel == SEL_W'(r))         rd_word = stat_w[r];
      if (sel == SEL_W'(N_REG + r)) rd_word = mask_w[r];
    end
    if (sel == SEL_W'(SEL_VMASK)) rd_word[N_REG-1:0] = vmask_q;
    if (sel == SEL_W'(SEL_CTRL)) begin
      rd_word[CTRL_EN_BIT]   = irq_en_q;
      rd_word[CTRL_LIVE_BIT] = live_q;
    end
  end

  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> (vec == '0)); // R6
  AST_VMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec & vmask_q) == '0)); // R5
  AST_CHRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rst |=> (!irq_en_q && !live_q && vmask_q == '0)); // R9
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqa_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int N_REG = 4,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int SEL_W  = $clog2(2 * N_REG + 2),
  localparam int ADDR_W = CH_W + SEL_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         init_n,
  input  logic [N_CH*N_REG*DATA_W-1:0] ev_pulse,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         rd_stb,
  input  logic                         wr_stb,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  output logic [N_CH*N_REG-1:0]        irq_vector,
  output logic                         irq_drive_low
);
  logic [CH_W-1:0]   ch_sel;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] ch_word [N_CH];
  logic [DATA_W-1:0] rd_mux;
  logic              any_vec;

  assign ch_sel = addr[ADDR_W-1:SEL_W];
  assign sel    = addr[SEL_W-1:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = (ch_sel == CH_W'(c));

    irqa_channel #(.N_REG(N_REG), .SEL_W(SEL_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_n  (init_n),
      .ev      (ev_pulse[c*N_REG*DATA_W +: N_REG*DATA_W]),
      .sel     (sel),
      .rd_stb  (rd_stb && hit),
      .wr_stb  (wr_stb && hit),
      .wr_data (wr_data),
      .rd_word (ch_word[c]),
      .vec     (irq_vector[c*N_REG +: N_REG])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (ch_sel == CH_W'(c)) rd_mux = ch_word[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_stb) begin
      rd_data <= rd_mux;
    end
  end

  assign any_vec       = |irq_vector;
  assign irq_drive_low = init_n && any_vec;

  AST_INIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> !irq_drive_low); // R8
  AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drive_low |-> (irq_vector != '0)); // R4
  AST_READ_PRECLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (rd_data == $past(rd_mux))); // R2
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data)); // R2
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam int N_CH = 4, N_REG = 4, W = 16;
  localparam int ADDR_W = 6;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EV = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_n = 1'b1;
  logic [N_CH*N_REG*W-1:0] ev_pulse = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [N_CH*N_REG-1:0] irq_vector;
  logic irq_drive_low;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .ev_pulse(ev_pulse),
    .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .irq_vector(irq_vector), .irq_drive_low(irq_drive_low)
  );

  // entry: {req[3:0], kind[1:0], ch[1:0], sel[3:0], data[15:0], exp_rd[15:0], exp_irq}
  localparam int NV = 28;
  localparam logic [44:0] TBL [NV] = '{
    {4'd4,  K_WR, 2'd0, 4'd9, 16'h0003, 16'h0000, 1'b0}, // R4 enable+live ch0
    {4'd1,  K_EV, 2'd0, 4'd1, 16'h0005, 16'h0000, 1'b1}, // R1
    {4'd2,  K_RD, 2'd0, 4'd1, 16'h0000, 16'h0005, 1'b0}, // R2
    {4'd10, K_WR, 2'd0, 4'd5, 16'h00FF, 16'h0000, 1'b0}, // R10 mask word 1
    {4'd3,  K_EV, 2'd0, 4'd1, 16'h0100, 16'h0000, 1'b1}, // R3 open bit
    {4'd2,  K_RD, 2'd0, 4'd1, 16'h0000, 16'h0100, 1'b0}, // R2
    {4'd3,  K_EV, 2'd0, 4'd1, 16'h0003, 16'h0000, 1'b0}, // R3 masked bits
    {4'd1,  K_RD, 2'd0, 4'd1, 16'h0000, 16'h0003, 1'b0}, // R1 latched though masked
    {4'd10, K_RD, 2'd0, 4'd5, 16'h0000, 16'h00FF, 1'b0}, // R10 mask readback
    {4'd5,  K_WR, 2'd0, 4'd8, 16'h0004, 16'h0000, 1'b0}, // R5 vmask word 2
    {4'd5,  K_EV, 2'd0, 4'd2, 16'h8000, 16'h0000, 1'b0}, // R5
    {4'd5,  K_RD, 2'd0, 4'd2, 16'h0000, 16'h8000, 1'b0}, // R5 still latched
    {4'd4,  K_EV, 2'd0, 4'd0, 16'h0001, 16'h0000, 1'b1}, // R4
    {4'd6,  K_WR, 2'd1, 4'd9, 16'h0002, 16'h0000, 1'b1}, // R6 ch1 live, suspended
    {4'd6,  K_EV, 2'd1, 4'd3, 16'h0010, 16'h0000, 1'b1}, // R6
    {4'd4,  K_RD, 2'd0, 4'd0, 16'h0000, 16'h0001, 1'b0}, // R4 ch1 cannot hold line
    {4'd6,  K_RD, 2'd1, 4'd3, 16'h0000, 16'h0010, 1'b0}, // R6 updated while suspended
    {4'd6,  K_RD, 2'd1, 4'd3, 16'h0000, 16'h0000, 1'b0}, // R6 cleared on read
    {4'd7,  K_EV, 2'd2, 4'd0, 16'hFFFF, 16'h0000, 1'b0}, // R7 ch2 not live
    {4'd7,  K_RD, 2'd2, 4'd0, 16'h0000, 16'h0000, 1'b0}, // R7
    {4'd10, K_WR, 2'd0, 4'd0, 16'hFFFF, 16'h0000, 1'b0}, // R10 status write ignored
    {4'd10, K_RD, 2'd0, 4'd0, 16'h0000, 16'h0000, 1'b0}, // R10
    {4'd10, K_RD, 2'd0, 4'd9, 16'h0000, 16'h0003, 1'b0}, // R10 ctrl readback
    {4'd4,  K_EV, 2'd0, 4'd0, 16'h0002, 16'h0000, 1'b1}, // R4
    {4'd4,  K_EV, 2'd0, 4'd3, 16'h0004, 16'h0000, 1'b1}, // R4
    {4'd4,  K_RD, 2'd0, 4'd0, 16'h0000, 16'h0002, 1'b1}, // R4 other word pending
    {4'd4,  K_RD, 2'd0, 4'd3, 16'h0000, 16'h0004, 1'b0}, // R4 all empty
    {4'd10, K_RD, 2'd0, 4'd8, 16'h0000, 16'h0004, 1'b0}  // R10 vmask readback
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ev_set(input int ch, input int r, input logic [W-1:0] d);
    ev_pulse[(ch*N_REG+r)*W +: W] = d;
  endtask

  // drive at a falling edge, release at the next one (one rising edge between)
  task automatic step(input logic [1:0] k, input int ch, input int sel, input logic [W-1:0] d);
    @(negedge clk);
    addr = {2'(ch), 4'(sel)};
    wr_data = d;
    if (k == K_WR) wr_stb = 1'b1;
    if (k == K_RD) rd_stb = 1'b1;
    if (k == K_EV) ev_set(ch, sel, d);
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; ev_pulse = '0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset rd_data", rd_data, 16'h0);
    check("R9 reset irq", {15'b0, irq_drive_low}, 16'h0);
    check("R9 reset vector", irq_vector, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] e;
      e = TBL[i];
      step(e[40:39], int'(e[38:37]), int'(e[36:33]), e[32:17]);
      if (e[40:39] == K_RD) check($sformatf("R%0d vec%0d rd_data", e[44:41], i), rd_data, e[16:1]);
      check($sformatf("R%0d vec%0d irq", e[44:41], i), {15'b0, irq_drive_low}, {15'b0, e[0]});
    end

    // R3: vector bit position c*N_REG+r
    step(K_EV, 0, 1, 16'h0100);
    check("R3 vector position", irq_vector, 16'h0002);
    step(K_RD, 0, 1, 16'h0);

    // R2: event and read of the same word in one cycle
    step(K_EV, 0, 0, 16'h0001);
    @(negedge clk);
    addr = {2'd0, 4'd0}; rd_stb = 1'b1; ev_set(0, 0, 16'h0010);
    @(negedge clk);
    rd_stb = 1'b0; ev_pulse = '0;
    check("R2 same-cycle old value", rd_data, 16'h0001);
    check("R2 same-cycle irq kept", {15'b0, irq_drive_low}, 16'h1);
    step(K_RD, 0, 0, 16'h0);
    check("R2 same-cycle survivor", rd_data, 16'h0010);
    check("R2 survivor cleared irq", {15'b0, irq_drive_low}, 16'h0);

    // R8: global init hold
    step(K_EV, 0, 0, 16'h0001);
    @(negedge clk);
    init_n = 1'b0;
    #1;
    check("R8 irq released at once", {15'b0, irq_drive_low}, 16'h0);
    step(K_EV, 0, 3, 16'h0008);
    @(negedge clk);
    init_n = 1'b1;
    #1;
    check("R8 irq stays released", {15'b0, irq_drive_low}, 16'h0);
    step(K_RD, 0, 0, 16'h0);
    check("R8 word0 cleared", rd_data, 16'h0);
    step(K_RD, 0, 3, 16'h0);
    check("R8 event ignored", rd_data, 16'h0);
    step(K_RD, 0, 5, 16'h0);
    check("R8 mask kept", rd_data, 16'h00FF);

    // R9: per-channel reset
    step(K_WR, 0, 9, 16'h0004);
    step(K_RD, 0, 5, 16'h0);
    check("R9 ch reset mask", rd_data, 16'h0);
    step(K_RD, 0, 9, 16'h0);
    check("R9 ch reset ctrl", rd_data, 16'h0);
    step(K_RD, 0, 8, 16'h0);
    check("R9 ch reset vmask", rd_data, 16'h0);
    step(K_RD, 1, 9, 16'h0);
    check("R9 other channel kept", rd_data, 16'h0002);

    // R9: global reset
    step(K_WR, 1, 4, 16'h1234);
    step(K_RD, 1, 4, 16'h0);
    check("R9 mask written", rd_data, 16'h1234);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 rd_data after reset", rd_data, 16'h0);
    step(K_RD, 1, 4, 16'h0);
    check("R9 mask after reset", rd_data, 16'h0);
    step(K_RD, 1, 9, 16'h0);
    check("R9 ctrl after reset", rd_data, 16'h0);

    summary();
  end
endmodule